// File: doc/BRIEF.md
# Debug TAP Chain Selector

This block is a debug test access port controller for a core-debug subsystem. A host drives the four JTAG pins and the optional asynchronous reset. The block has the standard sixteen-state TAP controller, a 5-bit instruction register and a 5-bit chain-number register. These steer the serial path between `tdi` and `tdo` to one of three debug chains, the chain-number register itself, or a one-bit bypass cell. The three debug chains are a 32-bit control/status word, a 32-bit instruction-transfer word and a 34-bit data/completion chain.

On the core side the block offers a one-cycle issue strobe with the transferred instruction word. It samples a 32-bit data word from the core, takes a completion pulse, and takes two abort inputs that feed sticky status bits. To run an instruction, the host writes the instruction-transfer word and then passes the controller through Run-Test/Idle. The host then polls the completion flag on the data chain until it reads 1. A shortcut opcode turns the port into a writer of the instruction-transfer chain with a single IR load. It leaves the stored chain number alone, so that later read and write opcodes go straight back to the chain the host chose before.

Top module: `dbg_tap_chainsel`

## Requirements
- R1: `trst_n` low, or five rising `tck` edges with `tms` high from any state, puts the controller in Test-Logic-Reset. Every Test-Logic-Reset cycle loads the bypass opcode 5'b11111 into the IR and clears the chain-number register to 0.
- R2: The IR shifts LSB first and captures 5'b00001. The opcodes are: external write 5'b00000, chain-number access 5'b00010, internal read 5'b01100, shortcut 5'b11101 and bypass 5'b11111. Every other opcode selects the 1-bit bypass cell, which captures 0.
- R3: With opcode 5'b00010 the 5-bit chain-number register is the data path. It captures 5'b10000, and Update-DR loads it with the shifted value.
- R4: Under opcodes 5'b01100 and 5'b00000 the chain number picks the path. Chain 1 is the 32-bit control word, chain 4 the 32-bit instruction word and chain 5 the 34-bit data chain. Every other number gives the 1-bit bypass cell. All chains shift LSB first, with `tdi` entering at the top bit of the chain.
- R5: After an IR update with opcode 5'b11101, the port acts as an external write of chain 4. The stored chain number is not changed, so a later 5'b01100 or 5'b00000 again uses it.
- R6: Update-DR changes a register only under opcodes 5'b00000, 5'b11101 and 5'b00010. Of the control word only bit 13 (execute enable) is writable. Writes to chain 5 have no effect.
- R7: Control-word bit 6 and bit 7 are sticky flags, set by `abort_prec_i` and `abort_imp_i`. Capturing the control word under 5'b01100 clears both flags. Capturing it under 5'b00000 leaves them set.
- R8: A write of chain 4 arms an issue request. On the next rising `tck` edge in Run-Test/Idle the request is consumed. If bit 13 is set and nothing is outstanding, `issue_o` pulses high for exactly one cycle and `instr_o` takes the written word. Otherwise the request is dropped.
- R9: Chain 5 captures bit 33 = 0, bit 32 = completion flag, and bits 31:0 = `core_data_i`. The flag resets to 1, clears when an instruction issues, and is set by `core_done_i`.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdo_en` is low.
- R11: A request consumed while an instruction is outstanding (completion flag 0) does not issue and leaves `instr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| core_data_i | input | 32 | Data word from the core model, captured into chain 5 |
| core_done_i | input | 1 | Completion pulse from the core model |
| abort_prec_i | input | 1 | Precise abort event, sets sticky bit 6 |
| abort_imp_i | input | 1 | Imprecise abort event, sets sticky bit 7 |
| issue_o | output | 1 | One-cycle instruction issue strobe |
| instr_o | output | 32 | Last issued instruction word |

## Verification
The hardest case to reach is an issue request that arrives while the previous instruction is still outstanding. To set it up, the bench sets the enable bit through the control chain and issues once through the shortcut opcode. It then writes a second word and passes Run-Test/Idle before pulsing `core_done_i`. The retention of the chain number under the shortcut is reached the same way: the bench selects chain 5, runs a shortcut write, and then does a plain read whose 34-bit length and contents show which chain was connected.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  localparam int IR_W  = 5;
  localparam int SEL_W = 5;

  // control word field positions
  localparam int EN_BIT   = 13;
  localparam int STKP_BIT = 6;
  localparam int STKI_BIT = 7;

  localparam logic [IR_W-1:0] OP_EXTEST = 5'b00000;
  localparam logic [IR_W-1:0] OP_SCANN  = 5'b00010;
  localparam logic [IR_W-1:0] OP_INTEST = 5'b01100;
  localparam logic [IR_W-1:0] OP_SHORT  = 5'b11101;
  localparam logic [IR_W-1:0] OP_BYPASS = 5'b11111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  localparam logic [SEL_W-1:0] CH_CTRL = 5'd1;
  localparam logic [SEL_W-1:0] CH_INSN = 5'd4;
  localparam logic [SEL_W-1:0] CH_DATA = 5'd5;
  localparam logic [SEL_W-1:0] SEL_CAPTURE = 5'b10000;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    TG_BYP, TG_SEL, TG_CTRL, TG_INSN, TG_DATA
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic wr;
  } route_t;

  function automatic tap_state_e tap_next(tap_state_e s, logic tms);
    tap_state_e r;
    r = S_TLR;
    case (s)
      S_TLR:    r = tms ? S_TLR    : S_RTI;
      S_RTI:    r = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: r = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: r = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  r = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: r = tms ? S_UPD_DR : S_PA_DR;
      S_PA_DR:  r = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: r = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: r = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: r = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: r = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  r = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: r = tms ? S_UPD_IR : S_PA_IR;
      S_PA_IR:  r = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: r = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: r = tms ? S_SEL_DR : S_RTI;
    endcase
    return r;
  endfunction

  function automatic tgt_e chain_tgt(logic [SEL_W-1:0] sel);
    tgt_e t;
    case (sel)
      CH_CTRL: t = TG_CTRL;
      CH_INSN: t = TG_INSN;
      CH_DATA: t = TG_DATA;
      default: t = TG_BYP;
    endcase
    return t;
  endfunction

  function automatic route_t route_of(logic [IR_W-1:0] ir, logic [SEL_W-1:0] sel);
    route_t r;
    case (ir)
      OP_SCANN:  r = '{tgt: TG_SEL,         wr: 1'b1};
      OP_INTEST: r = '{tgt: chain_tgt(sel), wr: 1'b0};
      OP_EXTEST: r = '{tgt: chain_tgt(sel), wr: 1'b1};
      OP_SHORT:  r = '{tgt: TG_INSN,        wr: 1'b1};
      default:   r = '{tgt: TG_BYP,         wr: 1'b0};
    endcase
    return r;
  endfunction

  function automatic int chain_len(tgt_e t, int word_w);
    int n;
    case (t)
      TG_SEL:  n = SEL_W;
      TG_CTRL: n = word_w;
      TG_INSN: n = word_w;
      TG_DATA: n = word_w + 2;
      default: n = 1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  output logic tlr_o,
  output logic rti_o,
  output logic cap_dr_o,
  output logic sh_dr_o,
  output logic upd_dr_o,
  output logic cap_ir_o,
  output logic sh_ir_o,
  output logic upd_ir_o
);

  tap_state_e state_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= S_TLR;
    else         state_q <= tap_next(state_q, tms);
  end

  assign tlr_o    = (state_q == S_TLR);
  assign rti_o    = (state_q == S_RTI);
  assign cap_dr_o = (state_q == S_CAP_DR);
  assign sh_dr_o  = (state_q == S_SH_DR);
  assign upd_dr_o = (state_q == S_UPD_DR);
  assign cap_ir_o = (state_q == S_CAP_IR);
  assign sh_ir_o  = (state_q == S_SH_IR);
  assign upd_ir_o = (state_q == S_UPD_IR);

  // R1: Update-DR is reached only from one of the two exit states
  p_upd_dr_entry_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == S_UPD_DR) |-> ($past(state_q) == S_EX1_DR || $past(state_q) == S_EX2_DR));

  // R1: five cycles of tms high always end in Test-Logic-Reset
  p_tms_high_reset_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == S_SEL_IR && tms) |=> (state_q == S_TLR));

endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
  import dbg_tap_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             tlr_i,
  input  logic             cap_ir_i,
  input  logic             sh_ir_i,
  input  logic             upd_ir_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ir_tdo_o,
  output route_t           route_o
);

  logic [IR_W-1:0] ir_sh_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh_q <= '0;
      ir_q    <= OP_BYPASS;
    end else begin
      if (cap_ir_i)     ir_sh_q <= IR_CAPTURE;
      else if (sh_ir_i) ir_sh_q <= {tdi, ir_sh_q[IR_W-1:1]};
      if (tlr_i)         ir_q <= OP_BYPASS;
      else if (upd_ir_i) ir_q <= ir_sh_q;
    end
  end

  assign ir_tdo_o = ir_sh_q[0];
  assign route_o  = route_of(ir_q, sel_i);

  // R1: a Test-Logic-Reset cycle leaves bypass in the IR
  p_tlr_bypass_r1: assert property (@(posedge tck) disable iff (!trst_n)
    tlr_i |=> (ir_q == OP_BYPASS));

  // R2: the IR only changes on an update or a reset cycle
  p_ir_hold_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_ir_i && !tlr_i) |=> $stable(ir_q));

  // R5: the shortcut opcode always routes as a chain-4 write
  p_short_route_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_ir_i && ir_sh_q == OP_SHORT) |=> (route_o.tgt == TG_INSN && route_o.wr));

endmodule

// File: rtl/dbg_tap_chains.sv
module dbg_tap_chains
  import dbg_tap_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              tlr_i,
  input  logic              rti_i,
  input  logic              cap_dr_i,
  input  logic              sh_dr_i,
  input  logic              upd_dr_i,
  input  route_t            route_i,
  input  logic [WORD_W-1:0] core_data_i,
  input  logic              core_done_i,
  input  logic              abort_prec_i,
  input  logic              abort_imp_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              dr_tdo_o,
  output logic              issue_o,
  output logic [WORD_W-1:0] instr_o
);

  localparam int DR_W = WORD_W + 2;

  logic [DR_W-1:0]   dr_q;
  logic [DR_W-1:0]   dr_shift;
  logic [DR_W-1:0]   dr_capture;
  logic [WORD_W-1:0] ctrl_word;
  logic [WORD_W-1:0] insn_q;
  logic [SEL_W-1:0]  sel_q;
  logic              en_q, stk_p_q, stk_i_q, done_q, pend_q, issue_q;
  int                cur_len;

  // named internal events
  logic ctrl_read_cap;
  logic insn_write;
  logic issue_fire;

  assign cur_len       = chain_len(route_i.tgt, WORD_W);
  assign ctrl_read_cap = cap_dr_i && route_i.tgt == TG_CTRL && !route_i.wr;
  assign insn_write    = upd_dr_i && route_i.wr && route_i.tgt == TG_INSN;
  assign issue_fire    = rti_i && pend_q && en_q && done_q;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[EN_BIT]   = en_q;
    ctrl_word[STKP_BIT] = stk_p_q;
    ctrl_word[STKI_BIT] = stk_i_q;
  end

  always_comb begin
    case (route_i.tgt)
      TG_SEL:  dr_capture = DR_W'(SEL_CAPTURE);
      TG_CTRL: dr_capture = DR_W'(ctrl_word);
      TG_INSN: dr_capture = DR_W'(insn_q);
      TG_DATA: dr_capture = {1'b0, done_q, core_data_i};
      default: dr_capture = '0;
    endcase
  end

  always_comb begin
    dr_shift = dr_q >> 1;
    for (int i = 0; i < DR_W; i++) begin
      if (i == cur_len - 1) dr_shift[i] = tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dr_q    <= '0;
      sel_q   <= '0;
      en_q    <= 1'b0;
      insn_q  <= '0;
      pend_q  <= 1'b0;
      issue_q <= 1'b0;
      instr_o <= '0;
      done_q  <= 1'b1;
      stk_p_q <= 1'b0;
      stk_i_q <= 1'b0;
    end else begin
      issue_q <= 1'b0;
      if (cap_dr_i)     dr_q <= dr_capture;
      else if (sh_dr_i) dr_q <= dr_shift;

      if (tlr_i) sel_q <= '0;
      else if (upd_dr_i && route_i.wr) begin
        case (route_i.tgt)
          TG_SEL:  sel_q  <= dr_q[SEL_W-1:0];
          TG_CTRL: en_q   <= dr_q[EN_BIT];
          TG_INSN: insn_q <= dr_q[WORD_W-1:0];
          default: ;
        endcase
      end

      if (insn_write)          pend_q <= 1'b1;
      else if (rti_i && pend_q) pend_q <= 1'b0;

      if (issue_fire) begin
        issue_q <= 1'b1;
        instr_o <= insn_q;
        done_q  <= 1'b0;
      end else if (core_done_i) begin
        done_q <= 1'b1;
      end

      if (abort_prec_i)       stk_p_q <= 1'b1;
      else if (ctrl_read_cap) stk_p_q <= 1'b0;
      if (abort_imp_i)        stk_i_q <= 1'b1;
      else if (ctrl_read_cap) stk_i_q <= 1'b0;
    end
  end

  assign sel_o    = sel_q;
  assign dr_tdo_o = dr_q[0];
  assign issue_o  = issue_q;

  // R5: the chain number moves only on a chain-number update or a reset cycle
  p_sel_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (!(upd_dr_i && route_i.tgt == TG_SEL) && !tlr_i) |=> $stable(sel_q));

  // R8: the strobe lasts one cycle and needs the enable bit
  p_issue_pulse_r8: assert property (@(posedge tck) disable iff (!trst_n)
    issue_q |=> !issue_q);
  p_issue_enabled_r8: assert property (@(posedge tck) disable iff (!trst_n)
    issue_q |-> $past(en_q));

  // R9: issuing clears the completion flag
  p_done_cleared_r9: assert property (@(posedge tck) disable iff (!trst_n)
    issue_q |-> !done_q);

  // R11: no issue while something is outstanding
  p_no_issue_busy_r11: assert property (@(posedge tck) disable iff (!trst_n)
    issue_q |-> $past(done_q));

  // R7: a read capture of the control word clears the precise flag
  p_sticky_clear_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (ctrl_read_cap && !abort_prec_i) |=> !stk_p_q);

endmodule

// File: rtl/dbg_tap_chainsel.sv
module dbg_tap_chainsel
  import dbg_tap_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_en,
  input  logic [WORD_W-1:0] core_data_i,
  input  logic              core_done_i,
  input  logic              abort_prec_i,
  input  logic              abort_imp_i,
  output logic              issue_o,
  output logic [WORD_W-1:0] instr_o
);

  logic tlr, rti, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
  logic ir_tdo, dr_tdo;
  logic [SEL_W-1:0] sel;
  route_t route;

  dbg_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms),
    .tlr_o(tlr), .rti_o(rti), .cap_dr_o(cap_dr), .sh_dr_o(sh_dr),
    .upd_dr_o(upd_dr), .cap_ir_o(cap_ir), .sh_ir_o(sh_ir), .upd_ir_o(upd_ir)
  );

  dbg_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tlr_i(tlr),
    .cap_ir_i(cap_ir), .sh_ir_i(sh_ir), .upd_ir_i(upd_ir),
    .sel_i(sel), .ir_tdo_o(ir_tdo), .route_o(route)
  );

  dbg_tap_chains #(.WORD_W(WORD_W)) u_chains (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tlr_i(tlr), .rti_i(rti),
    .cap_dr_i(cap_dr), .sh_dr_i(sh_dr), .upd_dr_i(upd_dr), .route_i(route),
    .core_data_i(core_data_i), .core_done_i(core_done_i),
    .abort_prec_i(abort_prec_i), .abort_imp_i(abort_imp_i),
    .sel_o(sel), .dr_tdo_o(dr_tdo), .issue_o(issue_o), .instr_o(instr_o)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= sh_ir | sh_dr;
      tdo    <= sh_ir ? ir_tdo : (sh_dr ? dr_tdo : 1'b0);
    end
  end

  // R10: the output is quiet outside the shift states
  p_tdo_quiet_r10: assert property (@(negedge tck) disable iff (!trst_n)
    !tdo_en |-> !tdo);

  // R10: output enable only follows a shift state
  p_tdo_en_shift_r10: assert property (@(negedge tck) disable iff (!trst_n)
    (!sh_ir && !sh_dr) |=> !tdo_en);

endmodule

// File: tb/dbg_tap_chainsel_tb.sv
module dbg_tap_chainsel_tb;

  localparam logic [31:0] DATA = 32'hA5C3_0F96;
  localparam int NSCAN = 48;

  typedef struct packed {
    logic [4:0]  op;
    logic [4:0]  sel;
    logic [5:0]  len;
    logic [33:0] cap;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{5'b11111, 5'd0, 6'd1,  34'h0},
    '{5'b00101, 5'd1, 6'd1,  34'h0},
    '{5'b00010, 5'd3, 6'd5,  34'h10},
    '{5'b01100, 5'd1, 6'd32, 34'h0},
    '{5'b01100, 5'd4, 6'd32, 34'h0},
    '{5'b01100, 5'd5, 6'd34, {2'b01, DATA}},
    '{5'b01100, 5'd7, 6'd1,  34'h0},
    '{5'b00000, 5'd2, 6'd1,  34'h0},
    '{5'b00000, 5'd5, 6'd34, {2'b01, DATA}},
    '{5'b11101, 5'd0, 6'd32, 34'h0}
  };

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, issue_o;
  logic [31:0] core_data_i = DATA, instr_o;
  logic core_done_i = 1'b0, abort_prec_i = 1'b0, abort_imp_i = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  dbg_tap_chainsel u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .core_data_i(core_data_i), .core_done_i(core_done_i),
    .abort_prec_i(abort_prec_i), .abort_imp_i(abort_imp_i),
    .issue_o(issue_o), .instr_o(instr_o)
  );

  always #5 tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [4:0] op, output logic [4:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) begin
      cap[i] = tdo;
      tick(i == 4, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din,
                         output logic [63:0] dout, output logic en_ok);
    dout = '0; en_ok = 1'b1;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (tdo_en !== 1'b1) en_ok = 1'b0;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic ir(input logic [4:0] op);
    logic [4:0] c;
    load_ir(op, c);
  endtask

  task automatic set_sel(input logic [4:0] s);
    logic [63:0] o; logic e;
    ir(5'b00010);
    scan_dr(5, {59'd0, s}, o, e);
  endtask

  function automatic logic [63:0] probe_exp(input int len, input logic [33:0] cap);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < NSCAN; i++) begin
      if (i < len) r[i] = cap[i];
      else         r[i] = (i == len);
    end
    return r;
  endfunction

  initial begin
    logic [63:0] o; logic e; logic [4:0] c;
    // reset state
    #12;
    chk("R10 tdo_en in reset", {63'd0, tdo_en}, 64'd0);
    chk("R10 tdo in reset", {63'd0, tdo}, 64'd0);
    chk("R8 issue_o in reset", {63'd0, issue_o}, 64'd0);
    chk("R8 instr_o in reset", {32'd0, instr_o}, 64'd0);
    @(negedge tck); trst_n = 1'b1; #1;
    tick(0, 0);
    scan_dr(NSCAN, 64'd1, o, e);
    chk("R1 bypass after trst", o, probe_exp(1, 34'd0));
    chk("R10 tdo_en during shift", {63'd0, e}, 64'd1);
    chk("R10 tdo_en after shift", {63'd0, tdo_en}, 64'd0);
    load_ir(5'b01100, c);
    chk("R2 IR capture", {59'd0, c}, 64'd1);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      set_sel(VEC[v].sel);
      ir(VEC[v].op);
      scan_dr(NSCAN, 64'd1, o, e);
      chk($sformatf("R4 row %0d (R2 R3 R5)", v), o, probe_exp(int'(VEC[v].len), VEC[v].cap));
    end

    // R1: tms-high reset clears IR and chain number
    set_sel(5'd5);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    scan_dr(NSCAN, 64'd1, o, e);
    chk("R1 IR bypass after tms reset", o, probe_exp(1, 34'd0));
    ir(5'b01100);
    scan_dr(NSCAN, 64'd1, o, e);
    chk("R1 chain number cleared", o, probe_exp(1, 34'd0));

    // R5: shortcut keeps the stored chain number
    set_sel(5'd5);
    ir(5'b11101);
    scan_dr(32, 64'h1234_ABCD, o, e);
    tick(0, 0);
    chk("R8 no issue with enable clear", {63'd0, issue_o}, 64'd0);
    ir(5'b01100);
    scan_dr(NSCAN, 64'd1, o, e);
    chk("R5 stored chain 5 reused", o, probe_exp(34, {2'b01, DATA}));
    set_sel(5'd4);
    ir(5'b01100);
    scan_dr(32, 64'd0, o, e);
    chk("R5 shortcut wrote chain 4", o, 64'h1234_ABCD);

    // R6: only bit 13 of the control word is writable; read does not write
    set_sel(5'd1);
    ir(5'b00000);
    scan_dr(32, 64'hFFFF_FFFF, o, e);
    ir(5'b01100);
    scan_dr(32, 64'd0, o, e);
    chk("R6 control write", o, 64'h2000);
    scan_dr(32, 64'd0, o, e);
    chk("R6 read-only scan keeps control", o, 64'h2000);
    set_sel(5'd5);
    ir(5'b00000);
    scan_dr(34, 64'd0, o, e);
    ir(5'b01100);
    scan_dr(34, 64'd0, o, e);
    chk("R6 chain 5 write ignored", o, {30'd0, 2'b01, DATA});

    // R8: issue
    ir(5'b11101);
    scan_dr(32, 64'hE1A0_0001, o, e);
    tick(0, 0);
    chk("R8 issue strobe", {63'd0, issue_o}, 64'd1);
    chk("R8 issued word", {32'd0, instr_o}, 64'hE1A0_0001);
    tick(0, 0);
    chk("R8 strobe one cycle", {63'd0, issue_o}, 64'd0);
    set_sel(5'd5);
    ir(5'b01100);
    scan_dr(34, 64'd0, o, e);
    chk("R9 flag clear while outstanding", o, {30'd0, 2'b00, DATA});

    // R11: request while outstanding
    ir(5'b11101);
    scan_dr(32, 64'h0BAD_0BAD, o, e);
    tick(0, 0);
    chk("R11 no issue while busy", {63'd0, issue_o}, 64'd0);
    chk("R11 instr_o kept", {32'd0, instr_o}, 64'hE1A0_0001);
    core_done_i = 1'b1; tick(0, 0); core_done_i = 1'b0;
    tick(0, 0);
    chk("R8 dropped request stays dropped", {63'd0, issue_o}, 64'd0);
    core_data_i = 32'h0F0F_3C3C;
    set_sel(5'd5);
    ir(5'b01100);
    scan_dr(34, 64'd0, o, e);
    chk("R9 flag set by done", o, {30'd0, 2'b01, 32'h0F0F_3C3C});

    // R7: sticky flags
    abort_prec_i = 1'b1; tick(0, 0); abort_prec_i = 1'b0;
    abort_imp_i = 1'b1; tick(0, 0); abort_imp_i = 1'b0;
    set_sel(5'd1);
    ir(5'b01100);
    scan_dr(32, 64'd0, o, e);
    chk("R7 sticky flags set", o, 64'h20C0);
    scan_dr(32, 64'd0, o, e);
    chk("R7 flags cleared by read", o, 64'h2000);
    abort_prec_i = 1'b1; tick(0, 0); abort_prec_i = 1'b0;
    ir(5'b00000);
    scan_dr(32, 64'h2000, o, e);
    chk("R7 write capture sees flag", o, 64'h2040);
    ir(5'b01100);
    scan_dr(32, 64'd0, o, e);
    chk("R7 write capture did not clear", o, 64'h2040);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule